// File: doc/BRIEF.md
# Chainable Serial Command/Status Slave

This block is the slave end of a four-wire serial link in SPI mode 0. It can share a bus with other slaves, each with its own select line, or it can sit as one link in a daisy chain where its serial output feeds the serial input of the next device. The block holds one internal shift register that is `WIDTH` bits wide. When the select line goes active, the shift register takes a parallel status word from the core logic. While the select stays active, each serial clock moves one bit in and one bit out, most significant bit first. When the select line is released, the shift register contents are copied into a parallel command register, and a single-cycle strobe tells the core that a new command has arrived.

The block never looks at bits in the middle of a frame. A frame with more clocks than `WIDTH` is therefore still valid. The extra bits pass through to the next device in the chain, delayed by exactly one word, and only the last `WIDTH` bits received become the command.

All serial pins are brought into the system clock domain through a synchronizer chain of `SYNC_STAGES` flops and then edge-detected. Every action of the block therefore happens on a system clock edge. The output-enable pin drives the external tri-state buffer for the serial output.

Top module: `spi_chain_slave`

## Requirements
- R1: While `rst` is high at a clock edge, `ser_out_en`, `ser_out`, `cmd_strobe` and `cmd_word` are all 0 after that edge.
- R2: `ser_out_en` is 1 exactly while the synchronized select is active (`sel_n` low). While the block is deselected it is 0, so the serial output can be released to high impedance.
- R3: When `sel_n` falls, `stat_word` is loaded into the shift register in one step. Its bit `WIDTH-1` appears on `ser_out` before the first rising edge of `ser_clk`.
- R4: While selected, a rising edge of `ser_clk` samples `ser_in` into bit 0 of the shift register and shifts the register toward its top bit. `ser_out` changes only after a falling edge of `ser_clk` and then shows the new top bit. The first `WIDTH` bits out are `stat_word` from bit `WIDTH-1` down to bit 0.
- R5: When `sel_n` rises after a frame of exactly `WIDTH` clocks, `cmd_word` holds the bits received, with the first bit received in bit `WIDTH-1`.
- R6: In a frame with more than `WIDTH` clocks, only the last `WIDTH` bits received reach `cmd_word`, and earlier bits have no effect.
- R7: From clock `WIDTH` onward within one frame, bit k on `ser_out` equals bit k-`WIDTH` that was received on `ser_in`.
- R8: A frame with no `ser_clk` edges writes the status word that was loaded at select into `cmd_word`.
- R9: `cmd_strobe` is high for exactly one system clock per select release, and `cmd_word` changes only in the cycle in which `cmd_strobe` is high.
- R10: `ser_clk` and `ser_in` activity while `sel_n` is high causes no strobe, does not change `cmd_word`, and leaves `ser_out_en` at 0.
- R11: A change on a serial pin takes effect at the outputs on the `SYNC_STAGES+1`-th system clock edge after it, which is the 3rd edge by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock from the master, idle low |
| sel_n | input | 1 | Active-low select |
| ser_in | input | 1 | Serial data in, from the master or the previous device in the chain |
| ser_out | output | 1 | Serial data out, to the master or the next device in the chain |
| ser_out_en | output | 1 | Output enable for the external tri-state buffer of `ser_out` |
| stat_word | input | WIDTH | Status word that is loaded when select asserts |
| cmd_word | output | WIDTH | Command register that is written when select releases |
| cmd_strobe | output | 1 | One-cycle pulse marking a new `cmd_word` |

## Verification
Every serial pin event reaches the outputs on the third system clock edge after the pin changes: two synchronizer flops and then one output register. The enable, the strobe and the new command word are all due on that edge, so the bench samples the strobe at the falling clock edges two and three cycles after select release and expects 0 and then 1. For the serial output, the bench holds each serial clock phase for five system clocks and reads `ser_out` only at the end of the low phase, well past its three-cycle update point. The bound properties check the same latency exactly by looking three samples back at the pins.

// File: rtl/spi_chain_pkg.sv
package spi_chain_pkg;

  // Serial pins as seen at one synchronizer stage.
  typedef struct packed {
    logic clk_l;
    logic sel_l;
    logic dat_l;
  } pin_bus_t;

  // Idle bus value: clock low, deselected, data low.
  localparam pin_bus_t PIN_IDLE = '{clk_l: 1'b0, sel_l: 1'b1, dat_l: 1'b0};

  // Events decoded from two adjacent synchronized samples.
  typedef struct packed {
    logic clk_rise;
    logic clk_fall;
    logic sel_start;
    logic sel_end;
    logic active;
    logic dat;
  } edge_set_t;

endpackage

// File: rtl/spi_chain_sync.sv
module spi_chain_sync
  import spi_chain_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  pin_bus_t  pins,
  output edge_set_t evt
);

  // One extra stage beyond the synchronizer gives the previous sample.
  localparam int DEPTH = STAGES + 1;

  pin_bus_t stage_q [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) stage_q[i] <= PIN_IDLE;
    end else begin
      stage_q[0] <= pins;
      for (int i = 1; i < DEPTH; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  pin_bus_t now_s, prev_s;
  assign now_s  = stage_q[STAGES-1];
  assign prev_s = stage_q[STAGES];

  always_comb begin
    evt.clk_rise  =  now_s.clk_l & ~prev_s.clk_l;
    evt.clk_fall  = ~now_s.clk_l &  prev_s.clk_l;
    evt.sel_start = ~now_s.sel_l &  prev_s.sel_l;
    evt.sel_end   =  now_s.sel_l & ~prev_s.sel_l;
    evt.active    = ~now_s.sel_l;
    evt.dat       =  now_s.dat_l;
  end

endmodule

// File: rtl/spi_chain_shifter.sv
module spi_chain_shifter #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             active,
  input  logic             clk_rise,
  input  logic             clk_fall,
  input  logic             dat,
  input  logic [WIDTH-1:0] stat_word,
  output logic [WIDTH-1:0] shift_q,
  output logic             out_q,
  output logic             oe_q
);

  localparam int TOP = WIDTH - 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_q <= '0;
      out_q   <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      oe_q <= active;
      if (load) begin
        shift_q <= stat_word;
        out_q   <= stat_word[TOP];
      end else if (active) begin
        if (clk_rise) shift_q <= {shift_q[TOP-1:0], dat};
        if (clk_fall) out_q   <= shift_q[TOP];
      end else begin
        out_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/spi_chain_cmd.sv
module spi_chain_cmd #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_end,
  input  logic [WIDTH-1:0] shift_q,
  output logic [WIDTH-1:0] cmd_q,
  output logic             strobe_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q    <= '0;
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= sel_end;
      if (sel_end) cmd_q <= shift_q;
    end
  end

endmodule

// File: rtl/spi_chain_slave.sv
module spi_chain_slave
  import spi_chain_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ser_clk,
  input  logic             sel_n,
  input  logic             ser_in,
  output logic             ser_out,
  output logic             ser_out_en,
  input  logic [WIDTH-1:0] stat_word,
  output logic [WIDTH-1:0] cmd_word,
  output logic             cmd_strobe
);

  pin_bus_t         pins;
  edge_set_t        evt;
  logic [WIDTH-1:0] shift_q;

  assign pins = '{clk_l: ser_clk, sel_l: sel_n, dat_l: ser_in};

  spi_chain_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .pins (pins),
    .evt  (evt)
  );

  spi_chain_shifter #(.WIDTH(WIDTH)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .load      (evt.sel_start),
    .active    (evt.active),
    .clk_rise  (evt.clk_rise),
    .clk_fall  (evt.clk_fall),
    .dat       (evt.dat),
    .stat_word (stat_word),
    .shift_q   (shift_q),
    .out_q     (ser_out),
    .oe_q      (ser_out_en)
  );

  spi_chain_cmd #(.WIDTH(WIDTH)) u_cmd (
    .clk      (clk),
    .rst      (rst),
    .sel_end  (evt.sel_end),
    .shift_q  (shift_q),
    .cmd_q    (cmd_word),
    .strobe_q (cmd_strobe)
  );

endmodule

// File: rtl/spi_chain_slave_chk.sv
module spi_chain_slave_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             ser_clk,
  input logic             sel_n,
  input logic             ser_out,
  input logic             ser_out_en,
  input logic [WIDTH-1:0] cmd_word,
  input logic             cmd_strobe
);

  // R2
  oe_off_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(sel_n, 3) |-> !ser_out_en);

  // R2
  oe_needs_select_chk: assert property (@(posedge clk) disable iff (rst)
    ser_out_en |-> !$past(sel_n, 3));

  // R4
  out_moves_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (ser_out_en && $past(ser_out_en) && (ser_out != $past(ser_out))) |-> !$past(ser_clk, 3));

  // R9
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_strobe |=> !cmd_strobe);

  // R9
  cmd_only_with_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_word != $past(cmd_word)) |-> cmd_strobe);

  // R11
  strobe_after_release_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_strobe |-> $past(sel_n, 3) && !$past(sel_n, 4));

endmodule

bind spi_chain_slave spi_chain_slave_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/spi_chain_slave_bench.sv
`timescale 1ns/1ps
module spi_chain_slave_bench;

  localparam int W  = 16;
  localparam int NV = 7;

  // status, clocks in frame, data sent MSB first from bit 31, expected command
  localparam logic [W-1:0] T_STAT [NV] = '{16'hA5C3, 16'h0F0F, 16'hFFFF, 16'h8001,
                                           16'h3C3C, 16'h1357, 16'h7E81};
  localparam int           T_NCLK [NV] = '{16, 16, 16, 32, 0, 24, 20};
  localparam logic [31:0]  T_DIN  [NV] = '{32'h1234_0000, 32'hFFFF_0000, 32'h0000_0000,
                                           32'hDEAD_BEEF, 32'h0000_0000, 32'hCAFE_F000,
                                           32'h9ABC_D000};
  localparam logic [W-1:0] T_EXP  [NV] = '{16'h1234, 16'hFFFF, 16'h0000, 16'hBEEF,
                                           16'h3C3C, 16'hFEF0, 16'hABCD};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_clk = 1'b0, sel_n = 1'b1, ser_in = 1'b0;
  logic ser_out, ser_out_en, cmd_strobe;
  logic [W-1:0] stat_word = '0;
  logic [W-1:0] cmd_word;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  spi_chain_slave #(.WIDTH(W), .SYNC_STAGES(2)) u_spi_chain_slave (
    .clk, .rst, .ser_clk, .sel_n, .ser_in, .ser_out, .ser_out_en,
    .stat_word, .cmd_word, .cmd_strobe
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_frame(input logic [W-1:0] st, input int n, input logic [31:0] din,
                           input logic [W-1:0] exp_cmd);
    string rq;
    logic  eb;
    rq = (n == 0) ? "R8" : (n > W) ? "R6" : "R5";
    stat_word = st;
    @(negedge clk);
    sel_n  = 1'b0;
    ser_in = (n > 0) ? din[31] : 1'b0;
    wait_n(6);
    chk(ser_out_en === 1'b1, "R2", 32'(ser_out_en), 1);
    for (int i = 0; i < n; i++) begin
      eb = (i < W) ? st[W-1-i] : din[31-(i-W)];
      chk(ser_out === eb, (i == 0) ? "R3" : (i < W) ? "R4" : "R7", 32'(ser_out), 32'(eb));
      ser_clk = 1'b1;
      wait_n(5);
      ser_clk = 1'b0;
      ser_in  = (i + 1 < n) ? din[30-i] : 1'b0;
      wait_n(5);
    end
    sel_n = 1'b1;
    wait_n(2);
    chk(cmd_strobe === 1'b0, "R11", 32'(cmd_strobe), 0);
    wait_n(1);
    chk(cmd_strobe === 1'b1, "R11", 32'(cmd_strobe), 1);
    chk(cmd_word === exp_cmd, rq, 32'(cmd_word), 32'(exp_cmd));
    chk(ser_out_en === 1'b0, "R2", 32'(ser_out_en), 0);
    wait_n(1);
    chk(cmd_strobe === 1'b0, "R9", 32'(cmd_strobe), 0);
    wait_n(3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [W-1:0] held;
    int           pulses;
    wait_n(4);
    // R1: reset state
    chk(ser_out_en === 1'b0, "R1", 32'(ser_out_en), 0);
    chk(cmd_strobe === 1'b0, "R1", 32'(cmd_strobe), 0);
    chk(cmd_word === '0, "R1", 32'(cmd_word), 0);
    chk(ser_out === 1'b0, "R1", 32'(ser_out), 0);
    rst = 1'b0;
    wait_n(4);

    for (int v = 0; v < NV; v++) run_frame(T_STAT[v], T_NCLK[v], T_DIN[v], T_EXP[v]);

    // R10: serial clocks while deselected
    held   = cmd_word;
    pulses = 0;
    for (int k = 0; k < 6; k++) begin
      ser_in  = k[0];
      ser_clk = 1'b1;
      for (int j = 0; j < 4; j++) begin @(negedge clk); pulses += int'(cmd_strobe); end
      ser_clk = 1'b0;
      for (int j = 0; j < 4; j++) begin @(negedge clk); pulses += int'(cmd_strobe); end
      chk(ser_out_en === 1'b0, "R10", 32'(ser_out_en), 0);
    end
    wait_n(4);
    chk(pulses == 0, "R10", 32'(pulses), 0);
    chk(cmd_word === held, "R10", 32'(cmd_word), 32'(held));

    // R8 again after idle clocks: the new status must come back unchanged
    run_frame(16'h5AA5, 0, 32'h0, 16'h5AA5);

    // R1: reset in the middle of a frame
    stat_word = 16'hC001;
    sel_n = 1'b0;
    wait_n(6);
    rst = 1'b1;
    wait_n(2);
    chk(ser_out_en === 1'b0, "R1", 32'(ser_out_en), 0);
    chk(cmd_word === '0, "R1", 32'(cmd_word), 0);
    sel_n = 1'b1;
    wait_n(4);
    rst = 1'b0;
    wait_n(6);
    chk(cmd_strobe === 1'b0, "R1", 32'(cmd_strobe), 0);

    finish_run();
  end

endmodule